// File: doc/BRIEF.md
# Windowed Watchdog Timer with Debug Masking

This block is a register-mapped watchdog timer. A 16-bit down-counter advances through two stages: an 8-bit prescaler, then a divider selected from four ratios. When the counter is due while already at zero, it reloads from a data register. That event can set a pending interrupt, fire a one-cycle system reset request, or both.

Software services the watchdog by writing the count register. In windowed mode, a service write that arrives while the live count is still above a programmed minimum is treated as a fault, with the same effect as an expiry. This catches software that kicks the watchdog too often as well as software that stops kicking it.

A debug-acknowledge input can hide both outputs while a debugger halts the core, provided the mask bit is set. The register bus is a plain single-cycle interface. A write is taken on every clock edge where the write enable is high. The read data follows the address combinationally. There is no back-pressure: the block never stalls the bus, so no ready signal exists.

Top module: `wdt_window_top`

## Requirements
- R1: After synchronous reset the control register reads 0x0000_8021, the data and count registers read 0x8000, the minimum-count register reads 0, and both outputs are low.
- R2: The register offsets are control 0x00, data 0x04, count 0x08, interrupt clear 0x0C and minimum count 0x10. Any other offset, and the clear register, read 0. Data and minimum keep the low 16 bits of a write. Control keeps bits 0 (reset enable), 2 (interrupt enable), 4:3 (divider code), 5 (timer enable), 15:8 (prescaler), 16 (debug mask) and 20 (window enable); all other control bits read 0.
- R3: With the timer enabled, prescaler value P and divider code D, the counter moves once every (P+1)*(16<<D) clock cycles. A move at a nonzero count decrements it. A move at zero reloads the data value and is an expiry, so a count of C written at edge E expires at edge E+(P+1)*(16<<D)*(C+1). An expiry sets the interrupt-pending flag (driven on the interrupt output) when the interrupt enable is set.
- R4: An expiry with the reset enable set drives the reset output high for exactly one cycle.
- R5: A write of any value to the interrupt-clear offset clears the pending interrupt.
- R6: With window mode on, a count-register write made while the live count is strictly greater than the minimum count is a fault. The fault sets the pending interrupt and the reset pulse as an expiry would, and the counter reloads from the data register instead of taking the written value.
- R7: While the debug mask bit is set and the debug-acknowledge input is high, both outputs are low. The pending flag is kept and shows again once the acknowledge input falls. With the mask bit clear, the acknowledge input has no effect.
- R8: With the timer disabled, the count does not change except by a count-register write.
- R9: A count-register write with window mode off, or with the live count not above the minimum, loads the written value with no fault and restarts the prescaler and divider from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wen | input | 1 | Register write enable, one write per cycle |
| bus_addr | input | 5 | Byte offset of the register being written or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dbg_ack | input | 1 | Debug acknowledge from the halted core |
| wdt_irq | output | 1 | Watchdog interrupt, level, until cleared |
| wdt_rst | output | 1 | System reset request, one-cycle pulse |

## Verification
Randomized rounds draw a prescaler value, a divider code, a starting count, a reload value and the two enables. Each round checks that no output appears one cycle before the computed expiry edge, and that the right outputs appear on that edge. This separates off-by-one errors in the prescaler, the divider and the zero-reload step, and it catches a swapped divider ratio. Directed service writes are made with the live count above, equal to and below the minimum, and with window mode off. These show whether the comparison is strict and whether the written value or the reload value is taken. Fault writes made with the debug acknowledge high, with and without the mask bit, check that masking hides the outputs without losing the pending interrupt.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int BUS_AW        = 5;
  localparam int BUS_DW        = 32;
  localparam int CNT_W         = 16;
  localparam int PRE_W         = 8;
  localparam int DIV_W         = 2;
  localparam int DIV_BASE_LOG2 = 4;
  localparam int DIV_CODES     = 1 << DIV_W;
  localparam int DCNT_W        = DIV_BASE_LOG2 + DIV_CODES - 1;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 5'h00;
  localparam logic [BUS_AW-1:0] OFS_DATA = 5'h04;
  localparam logic [BUS_AW-1:0] OFS_CNT  = 5'h08;
  localparam logic [BUS_AW-1:0] OFS_CLR  = 5'h0C;
  localparam logic [BUS_AW-1:0] OFS_MIN  = 5'h10;

  localparam int B_RST = 0;
  localparam int B_IRQ = 2;
  localparam int B_DIV = 3;
  localparam int B_TMR = 5;
  localparam int B_PRE = 8;
  localparam int B_DBG = 16;
  localparam int B_WIN = 20;

  typedef struct packed {
    logic             win;
    logic             dbg;
    logic [PRE_W-1:0] presc;
    logic             tmr;
    logic [DIV_W-1:0] div;
    logic             irq;
    logic             rst;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{win: 1'b0, dbg: 1'b0, presc: PRE_W'(128),
                                 tmr: 1'b1, div: '0, irq: 1'b0, rst: 1'b1};
  localparam logic [CNT_W-1:0] DATA_RST = CNT_W'(16'h8000);
  localparam logic [CNT_W-1:0] CNT_RST  = CNT_W'(16'h8000);
  localparam logic [CNT_W-1:0] MIN_RST  = '0;

  function automatic logic [BUS_DW-1:0] pack_ctrl(input ctrl_t c);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[B_RST]            = c.rst;
    w[B_IRQ]            = c.irq;
    w[B_DIV +: DIV_W]   = c.div;
    w[B_TMR]            = c.tmr;
    w[B_PRE +: PRE_W]   = c.presc;
    w[B_DBG]            = c.dbg;
    w[B_WIN]            = c.win;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(input logic [BUS_DW-1:0] w);
    ctrl_t c;
    c.rst   = w[B_RST];
    c.irq   = w[B_IRQ];
    c.div   = w[B_DIV +: DIV_W];
    c.tmr   = w[B_TMR];
    c.presc = w[B_PRE +: PRE_W];
    c.dbg   = w[B_DBG];
    c.win   = w[B_WIN];
    return c;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic [BUS_DW-1:0] bus_rdata,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  data_q,
  output logic [CNT_W-1:0]  min_q,
  output logic              cnt_wr,
  output logic              clr_wr,
  output logic [CNT_W-1:0]  cnt_wval
);
  assign cnt_wr   = bus_wen && (bus_addr == OFS_CNT);
  assign clr_wr   = bus_wen && (bus_addr == OFS_CLR);
  assign cnt_wval = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      data_q <= DATA_RST;
      min_q  <= MIN_RST;
    end else if (bus_wen) begin
      case (bus_addr)
        OFS_CTRL: ctrl_q <= unpack_ctrl(bus_wdata);
        OFS_DATA: data_q <= bus_wdata[CNT_W-1:0];
        OFS_MIN:  min_q  <= bus_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = pack_ctrl(ctrl_q);
      OFS_DATA: bus_rdata = BUS_DW'(data_q);
      OFS_CNT:  bus_rdata = BUS_DW'(cnt_q);
      OFS_MIN:  bus_rdata = BUS_DW'(min_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [PRE_W-1:0]  pre_q;
  logic [DCNT_W-1:0] div_q;
  logic [DCNT_W-1:0] last_tab [DIV_CODES];
  logic [DCNT_W-1:0] div_last;
  logic              pre_hit;

  for (genvar g = 0; g < DIV_CODES; g++) begin : g_last
    assign last_tab[g] = DCNT_W'((1 << (DIV_BASE_LOG2 + g)) - 1);
  end

  assign div_last = last_tab[div_sel];
  assign pre_hit  = run && (pre_q == presc);
  assign tick     = pre_hit && (div_q == div_last);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (pre_hit) begin
      pre_q <= '0;
      div_q <= (div_q == div_last) ? '0 : div_q + DCNT_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             win_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic [CNT_W-1:0] data_q,
  input  logic [CNT_W-1:0] min_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire
);
  logic early;
  logic at_zero;

  assign early   = win_en && (cnt_q > min_q);
  assign at_zero = (cnt_q == '0);
  assign fire    = cnt_wr ? early : (tick && at_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_RST;
    end else if (cnt_wr) begin
      cnt_q <= early ? data_q : cnt_wval;
    end else if (tick) begin
      cnt_q <= at_zero ? data_q : cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic irq_en,
  input  logic rst_en,
  input  logic clr_wr,
  input  logic mask_en,
  input  logic dbg_ack,
  output logic irq_pend,
  output logic wdt_irq,
  output logic wdt_rst
);
  logic pulse_q;
  logic hide;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (fire && irq_en) irq_pend <= 1'b1;
      else if (clr_wr)    irq_pend <= 1'b0;
      pulse_q <= fire && rst_en;
    end
  end

  assign hide    = mask_en && dbg_ack;
  assign wdt_irq = irq_pend && !hide;
  assign wdt_rst = pulse_q && !hide;
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              dbg_ack,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] data_q;
  logic [CNT_W-1:0] min_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_wval;
  logic             cnt_wr;
  logic             clr_wr;
  logic             tick;
  logic             fire;
  logic             irq_pend;

  wdt_regs u_regs (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_q(cnt_q), .bus_rdata(bus_rdata),
    .ctrl_q(ctrl_q), .data_q(data_q), .min_q(min_q),
    .cnt_wr(cnt_wr), .clr_wr(clr_wr), .cnt_wval(cnt_wval)
  );

  wdt_tick u_tick (
    .clk(clk), .rst(rst), .run(ctrl_q.tmr), .restart(cnt_wr),
    .presc(ctrl_q.presc), .div_sel(ctrl_q.div), .tick(tick)
  );

  wdt_core u_core (
    .clk(clk), .rst(rst), .tick(tick), .win_en(ctrl_q.win),
    .cnt_wr(cnt_wr), .cnt_wval(cnt_wval), .data_q(data_q), .min_q(min_q),
    .cnt_q(cnt_q), .fire(fire)
  );

  wdt_alarm u_alarm (
    .clk(clk), .rst(rst), .fire(fire), .irq_en(ctrl_q.irq),
    .rst_en(ctrl_q.rst), .clr_wr(clr_wr), .mask_en(ctrl_q.dbg),
    .dbg_ack(dbg_ack), .irq_pend(irq_pend), .wdt_irq(wdt_irq),
    .wdt_rst(wdt_rst)
  );
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wen,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              dbg_ack,
  input logic              wdt_irq,
  input logic              wdt_rst,
  input ctrl_t             ctrl_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  data_q,
  input logic [CNT_W-1:0]  min_q,
  input logic              tick,
  input logic              irq_pend
);
  logic wr_cnt;
  logic wr_clr;
  assign wr_cnt = bus_wen && (bus_addr == OFS_CNT);
  assign wr_clr = bus_wen && (bus_addr == OFS_CLR);

  a_r7_debug_hides: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.dbg && dbg_ack) |-> (!wdt_irq && !wdt_rst));

  a_r3_zero_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt_q == '0 && !wr_cnt) |=> (cnt_q == $past(data_q)));

  a_r3_tick_needs_enable: assert property (@(posedge clk) disable iff (rst)
    tick |-> ctrl_q.tmr);

  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.tmr && !wr_cnt) |=> $stable(cnt_q));

  a_r6_early_kick: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && ctrl_q.win && ctrl_q.irq && cnt_q > min_q) |=> irq_pend);

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !ctrl_q.irq) |=> !irq_pend);

  a_r4_pulse_enabled: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst) |-> $past(ctrl_q.rst));
endmodule

bind wdt_window_top wdt_window_chk u_chk (
  .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
  .dbg_ack(dbg_ack), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .data_q(data_q), .min_q(min_q),
  .tick(tick), .irq_pend(irq_pend)
);

// File: tb/tb_wdt_window_top.sv
module tb_wdt_window_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  localparam logic [4:0] A_CTRL = 5'h00, A_DATA = 5'h04, A_CNT = 5'h08,
                         A_CLR = 5'h0C, A_MIN = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_ack = 1'b0;
  logic        wdt_irq;
  logic        wdt_rst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  wdt_window_top dut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_ack(dbg_ack),
    .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period(input int p, input int d);
    return (p + 1) * (16 << d);
  endfunction

  function automatic logic [31:0] ctrl_word(input bit tmr, input bit ie, input bit re,
                                            input int d, input int p, input bit dbg, input bit win);
    return (32'(win) << 20) | (32'(dbg) << 16) | (32'(p) << 8) | (32'(tmr) << 5)
         | (32'(d) << 3) | (32'(ie) << 2) | 32'(re);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20231011));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0000_8021);
    rd(A_DATA, v); chk("R1 data", v, 32'h0000_8000);
    rd(A_CNT, v);  chk("R1 count", v, 32'h0000_8000);
    rd(A_MIN, v);  chk("R1 min", v, 32'h0);
    chk("R1 irq low", 32'(wdt_irq), 32'h0);
    chk("R1 rst low", 32'(wdt_rst), 32'h0);

    // R8 disabled timer holds count
    wr(A_CTRL, 32'h0);
    repeat (60) @(negedge clk);
    rd(A_CNT, v); chk("R8 count held", v, 32'h0000_8000);

    // R2 register map
    wr(A_DATA, 32'h1234_5678); rd(A_DATA, v); chk("R2 data low half", v, 32'h0000_5678);
    wr(A_MIN, 32'hFFFF_ABCD);  rd(A_MIN, v);  chk("R2 min low half", v, 32'h0000_ABCD);
    rd(A_CLR, v);   chk("R2 clear reads 0", v, 32'h0);
    rd(5'h14, v);   chk("R2 unmapped reads 0", v, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R2 ctrl fields", v, 32'h0011_FF3D);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, v);   chk("R2 count untouched", v, 32'h0000_8000);
    wr(A_MIN, 32'h0);

    // R3 R4 R5 randomized expiry rounds
    for (int t = 0; t < 12; t++) begin
      int p, d, c, n, dv;
      bit ie, re;
      p  = int'($urandom % 4);
      d  = (t < 4) ? t : int'($urandom % 4);
      c  = int'($urandom % 4);
      dv = int'($urandom % 16);
      ie = (t == 0) ? 1'b1 : 1'($urandom % 2);
      re = (t == 1) ? 1'b1 : 1'($urandom % 2);
      n  = period(p, d) * (c + 1);
      wr(A_CTRL, 32'h0);
      wr(A_CLR, 32'h0);
      wr(A_DATA, 32'(dv));
      wr(A_CTRL, ctrl_word(1'b1, ie, re, d, p, 1'b0, 1'b0));
      wr(A_CNT, 32'(c));
      repeat (n - 1) @(negedge clk);
      chk("R3 no early irq", 32'(wdt_irq), 32'h0);
      chk("R4 no early reset", 32'(wdt_rst), 32'h0);
      @(negedge clk);
      chk("R3 irq at expiry", 32'(wdt_irq), 32'(ie));
      chk("R4 reset at expiry", 32'(wdt_rst), 32'(re));
      rd(A_CNT, v); chk("R3 reload value", v, 32'(dv));
      @(negedge clk);
      chk("R4 reset one cycle", 32'(wdt_rst), 32'h0);
      if (ie) begin
        wr(A_CLR, 32'hDEAD_BEEF);
        chk("R5 irq cleared", 32'(wdt_irq), 32'h0);
      end
    end

    // R9 and R6 window behaviour, timer off
    wr(A_CTRL, ctrl_word(1'b0, 1'b1, 1'b1, 0, 0, 1'b0, 1'b0));
    wr(A_CLR, 32'h0);
    wr(A_MIN, 32'd5);
    wr(A_DATA, 32'd4);
    wr(A_CNT, 32'd10);
    rd(A_CNT, v); chk("R9 window off load", v, 32'd10);
    chk("R9 window off no irq", 32'(wdt_irq), 32'h0);
    chk("R9 window off no reset", 32'(wdt_rst), 32'h0);
    wr(A_CTRL, ctrl_word(1'b0, 1'b1, 1'b1, 0, 0, 1'b0, 1'b1));
    wr(A_CNT, 32'd3);
    chk("R6 early kick irq", 32'(wdt_irq), 32'h1);
    chk("R6 early kick reset", 32'(wdt_rst), 32'h1);
    rd(A_CNT, v); chk("R6 reload on fault", v, 32'd4);
    @(negedge clk);
    chk("R6 reset one cycle", 32'(wdt_rst), 32'h0);
    wr(A_CLR, 32'h0);
    wr(A_CNT, 32'd5);
    rd(A_CNT, v); chk("R9 below min load", v, 32'd5);
    chk("R9 below min no irq", 32'(wdt_irq), 32'h0);
    wr(A_CNT, 32'd9);
    rd(A_CNT, v); chk("R9 equal min load", v, 32'd9);
    chk("R9 equal min no irq", 32'(wdt_irq), 32'h0);
    chk("R9 equal min no reset", 32'(wdt_rst), 32'h0);

    // R7 debug masking
    wr(A_CTRL, ctrl_word(1'b0, 1'b1, 1'b1, 0, 0, 1'b1, 1'b1));
    dbg_ack = 1'b1;
    wr(A_CNT, 32'd2);
    chk("R7 reset hidden", 32'(wdt_rst), 32'h0);
    chk("R7 irq hidden", 32'(wdt_irq), 32'h0);
    dbg_ack = 1'b0; #1;
    chk("R7 irq kept pending", 32'(wdt_irq), 32'h1);
    dbg_ack = 1'b1;
    wr(A_CTRL, ctrl_word(1'b0, 1'b1, 1'b1, 0, 0, 1'b0, 1'b1));
    chk("R7 ack ignored unmasked", 32'(wdt_irq), 32'h1);
    dbg_ack = 1'b0;
    wr(A_CLR, 32'h0);
    chk("R5 clear after debug", 32'(wdt_irq), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule